// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

This block is a purely combinational integer arithmetic-logic unit for a simple load/store processor datapath. It is built from a chain of identical one-bit slices. Each slice can complement either of its operand bits, and then picks one of four candidate outputs: the bitwise AND, the bitwise OR, the full-adder sum, or a "less" input. The carries ripple from the least significant slice to the most significant one.

The 4-bit operation code is decoded in the structure itself, not by a separate decoder. Bit 3 complements operand A. Bit 2 complements operand B and also supplies the carry into slice 0. Bits 1:0 select the slice output. This turns subtraction into an addition of the complemented operand plus one, and NOR into an AND of the two complemented operands.

The top slice also computes the signed overflow of the adder and a corrected "set" bit. The set bit feeds back into the less input of slice 0 to implement signed set-on-less-than. Codes outside the six supported operations give an all-zero result.

Top module: `slice_alu`

## Requirements
- R1: Operation code 4'b0000 gives `res = opa & opb`.
- R2: Operation code 4'b0001 gives `res = opa | opb`.
- R3: Operation code 4'b0010 gives `res = (opa + opb) mod 2^W`.
- R4: Operation code 4'b0110 gives `res = (opa - opb) mod 2^W`.
- R5: Operation code 4'b1100 gives `res = ~(opa | opb)`.
- R6: Operation code 4'b0111 gives `res[0] = 1` when `opa < opb` as signed two's-complement values, and 0 otherwise. Bits W-1:1 are 0. The answer stays correct when the internal subtraction overflows; for example, 0x80000000 vs 0x7fffffff gives 1.
- R7: For codes 4'b0010 and 4'b0110, `ovf` is 1 exactly when the signed result cannot be represented in W bits. For addition that means equal operand signs and a result sign that differs from them. For subtraction it means differing operand signs and a result sign that differs from `opa`.
- R8: For codes 4'b0000, 4'b0001, 4'b0111 and 4'b1100, `ovf` is 0, even when the internal adder overflows.
- R9: `zero` is 1 exactly when all W bits of `res` are 0.
- R10: Every code other than the six listed above gives `res = 0` and `ovf = 0`, so `zero = 1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | W (32) | First operand |
| opb | input | W (32) | Second operand |
| op | input | 4 | Operation code |
| res | output | W (32) | Result |
| zero | output | 1 | High when the result is all zeros |
| ovf | output | 1 | Signed overflow for add/subtract |

## Verification
The assertions are immediate checks that run whenever the inputs settle. They assume that `opa`, `opb` and `op` are free of X and Z and change only as whole vectors. The bench meets this by driving every input from one task on the falling clock edge. It reads the outputs two nanoseconds later, so the ripple chain has settled before any check runs. The stimulus covers each supported code, including operands that overflow the adder. It also covers a sweep of every unused code, so the checks that are conditional on the operation code all get exercised.

// File: rtl/slice_alu_pkg.sv
package slice_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'b0000,
    OP_OR  = 4'b0001,
    OP_ADD = 4'b0010,
    OP_SUB = 4'b0110,
    OP_SLT = 4'b0111,
    OP_NOR = 4'b1100
  } alu_op_e;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } slice_sel_e;

  function automatic logic op_known(input logic [3:0] code);
    case (code)
      OP_AND, OP_OR, OP_ADD, OP_SUB, OP_SLT, OP_NOR: op_known = 1'b1;
      default:                                       op_known = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/alu_slice.sv
module alu_slice
  import slice_alu_pkg::*;
(
  input  logic       ai,
  input  logic       bi,
  input  logic       ainv,
  input  logic       binv,
  input  logic       less,
  input  logic       cin,
  input  logic [1:0] sel,
  output logic       res,
  output logic       cout
);
  logic a_eff, b_eff, sum;

  assign a_eff = ai ^ ainv;
  assign b_eff = bi ^ binv;
  assign sum   = a_eff ^ b_eff ^ cin;
  assign cout  = (a_eff & b_eff) | (cin & (a_eff ^ b_eff));

  always_comb begin
    case (slice_sel_e'(sel))
      SEL_AND:  res = a_eff & b_eff;
      SEL_OR:   res = a_eff | b_eff;
      SEL_SUM:  res = sum;
      default:  res = less;
    endcase
  end
endmodule

// File: rtl/alu_msb_slice.sv
module alu_msb_slice
  import slice_alu_pkg::*;
(
  input  logic       ai,
  input  logic       bi,
  input  logic       ainv,
  input  logic       binv,
  input  logic       less,
  input  logic       cin,
  input  logic [1:0] sel,
  output logic       res,
  output logic       set_o,
  output logic       ovf_o
);
  logic a_eff, b_eff, sum, cout;

  assign a_eff = ai ^ ainv;
  assign b_eff = bi ^ binv;
  assign sum   = a_eff ^ b_eff ^ cin;
  assign cout  = (a_eff & b_eff) | (cin & (a_eff ^ b_eff));
  // signed overflow: carry into the top bit differs from carry out of it
  assign ovf_o = cin ^ cout;
  // sign of the true difference, corrected for overflow
  assign set_o = sum ^ ovf_o;

  always_comb begin
    case (slice_sel_e'(sel))
      SEL_AND:  res = a_eff & b_eff;
      SEL_OR:   res = a_eff | b_eff;
      SEL_SUM:  res = sum;
      default:  res = less;
    endcase
  end
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int W = 32
) (
  input  logic [W-1:0] val,
  output logic         is_zero
);
  assign is_zero = ~|val;
endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import slice_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [3:0]   op,
  output logic [W-1:0] res,
  output logic         zero,
  output logic         ovf
);
  localparam int MSB = W - 1;

  logic         a_inv, b_inv;
  logic [1:0]   sel;
  logic [W-1:0] carry;
  logic [W-1:0] raw;
  logic         msb_set, msb_ovf, known;

  assign a_inv    = op[3];
  assign b_inv    = op[2];
  assign sel      = op[1:0];
  assign carry[0] = op[2];
  assign known    = op_known(op);

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      if (i == MSB) begin : g_top
        alu_msb_slice u_sl (
          .ai(opa[i]), .bi(opb[i]), .ainv(a_inv), .binv(b_inv),
          .less(1'b0), .cin(carry[i]), .sel(sel),
          .res(raw[i]), .set_o(msb_set), .ovf_o(msb_ovf)
        );
      end else if (i == 0) begin : g_low
        alu_slice u_sl (
          .ai(opa[i]), .bi(opb[i]), .ainv(a_inv), .binv(b_inv),
          .less(msb_set), .cin(carry[i]), .sel(sel),
          .res(raw[i]), .cout(carry[i+1])
        );
      end else begin : g_mid
        alu_slice u_sl (
          .ai(opa[i]), .bi(opb[i]), .ainv(a_inv), .binv(b_inv),
          .less(1'b0), .cin(carry[i]), .sel(sel),
          .res(raw[i]), .cout(carry[i+1])
        );
      end
    end
  endgenerate

  assign res = known ? raw : '0;
  assign ovf = known && (slice_sel_e'(sel) == SEL_SUM) && msb_ovf;

  alu_zero_detect #(.W(W)) u_zero (
    .val(res),
    .is_zero(zero)
  );
endmodule

// File: rtl/slice_alu_chk.sv
module slice_alu_chk
  import slice_alu_pkg::*;
#(
  parameter int W = 32
) (
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [3:0]   op,
  input logic [W-1:0] res,
  input logic         zero,
  input logic         ovf
);
  always_comb begin
    if (!$isunknown({opa, opb, op, res, zero, ovf})) begin
      // R3
      add_sum_chk: assert (op != OP_ADD || res == opa + opb);
      // R4
      sub_diff_chk: assert (op != OP_SUB || res == opa - opb);
      // R6
      slt_bit_chk: assert (op != OP_SLT ||
                           res == W'($signed(opa) < $signed(opb)));
      // R7
      add_ovf_chk: assert (op != OP_ADD ||
        ovf == ((opa[W-1] == opb[W-1]) && (res[W-1] != opa[W-1])));
      // R8
      no_overflow_chk: assert (op == OP_ADD || op == OP_SUB || !ovf);
      // R9
      zero_flag_chk: assert (zero == (res == '0));
      // R10
      unknown_op_chk: assert (op_known(op) || (res == '0 && !ovf));
    end
  end
endmodule

bind slice_alu slice_alu_chk #(.W(W)) u_chk (
  .opa(opa), .opb(opb), .op(op), .res(res), .zero(zero), .ovf(ovf)
);

// File: tb/sim_slice_alu.sv
`timescale 1ns/1ps
module sim_slice_alu;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] opa = '0, opb = '0;
  logic [3:0]   op = 4'b0000;
  logic [W-1:0] res;
  logic         zero, ovf;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  slice_alu #(.W(W)) u0 (
    .opa(opa), .opb(opb), .op(op), .res(res), .zero(zero), .ovf(ovf)
  );

  function automatic logic [W-1:0] model_res(input logic [W-1:0] x, y,
                                             input logic [3:0] c);
    case (c)
      4'b0000: model_res = x & y;
      4'b0001: model_res = x | y;
      4'b0010: model_res = x + y;
      4'b0110: model_res = x - y;
      4'b0111: model_res = ($signed(x) < $signed(y)) ? 1 : 0;
      4'b1100: model_res = ~(x | y);
      default: model_res = '0;
    endcase
  endfunction

  function automatic logic model_ovf(input logic [W-1:0] x, y,
                                     input logic [3:0] c);
    logic [W-1:0] r;
    r = model_res(x, y, c);
    if (c == 4'b0010)      model_ovf = (x[W-1] == y[W-1]) && (r[W-1] != x[W-1]);
    else if (c == 4'b0110) model_ovf = (x[W-1] != y[W-1]) && (r[W-1] != x[W-1]);
    else                   model_ovf = 1'b0;
  endfunction

  task automatic run(input logic [W-1:0] x, y, input logic [3:0] c,
                     input string tag);
    logic [W-1:0] er;
    logic eo, ez;
    @(negedge clk);
    opa = x; opb = y; op = c;
    #2;
    er = model_res(x, y, c);
    eo = model_ovf(x, y, c);
    ez = (er == '0);
    total++;
    if (res !== er || ovf !== eo || zero !== ez) begin
      bad++;
      $display("FAIL %s op=%b a=%h b=%h: res=%h ovf=%b zero=%b expected res=%h ovf=%b zero=%b",
               tag, c, x, y, res, ovf, zero, er, eo, ez);
    end
  endtask

  task automatic t_reset_state();
    run('0, '0, 4'b0000, "R1/R9 idle");
  endtask

  task automatic t_logic();
    run(32'hffffffff, 32'hffffffff, 4'b0000, "R1");
    run(32'h0f0f0f0f, 32'hf0f0f0f0, 4'b0000, "R1");
    run(32'h0f0f0f0f, 32'hf0f0f0f0, 4'b0001, "R2");
    run(32'h12340000, 32'h00005678, 4'b0001, "R2");
    run(32'h00000000, 32'hffffffff, 4'b1100, "R5 R9");
    run(32'h0000ff00, 32'h00f00000, 4'b1100, "R5");
  endtask

  task automatic t_arith();
    run(32'h11451400, 32'h19191800, 4'b0010, "R3");
    run(32'h00000000, 32'h00000000, 4'b0010, "R3 R9");
    run(32'h24342434, 32'h67676767, 4'b0110, "R4");
    run(32'd10, 32'd10, 4'b0110, "R4 R9");
  endtask

  task automatic t_overflow();
    run(32'h7fffffff, 32'h00000001, 4'b0010, "R7");
    run(32'h80000000, 32'hffffffff, 4'b0010, "R7");
    run(32'h7fffffff, 32'hffffffff, 4'b0110, "R7");
    run(32'h80000000, 32'h00000001, 4'b0110, "R7");
    run(32'h7fffffff, 32'h00000001, 4'b0001, "R8");
    run(32'h80000000, 32'h80000000, 4'b1100, "R8");
    run(32'h80000000, 32'h7fffffff, 4'b0111, "R8");
  endtask

  task automatic t_slt();
    run(32'd10, 32'd20, 4'b0111, "R6");
    run(32'd20, 32'd10, 4'b0111, "R6");
    run(-32'sd5, -32'sd2, 4'b0111, "R6");
    run(-32'sd2, -32'sd5, 4'b0111, "R6");
    run(32'd7, 32'd7, 4'b0111, "R6");
    run(32'h80000000, 32'h7fffffff, 4'b0111, "R6");
    run(32'h7fffffff, 32'h80000000, 4'b0111, "R6");
  endtask

  task automatic t_unused();
    for (int k = 0; k < 16; k++) begin
      if (!(k inside {0, 1, 2, 6, 7, 12}))
        run(32'h7fffffff, 32'h7fffffff, 4'(k), "R10");
    end
  endtask

  task automatic t_random();
    logic [3:0] codes [6] = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100};
    for (int k = 0; k < 600; k++) begin
      run($urandom(), $urandom(), codes[k % 6], "R1-R9 random");
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset_state();
    t_logic();
    t_arith();
    t_overflow();
    t_slt();
    t_unused();
    t_random();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule